// File: doc/BRIEF.md
# Overwriting Circular Return Stack

This block holds return addresses and saved context for a sequencer. On every call or interrupt entry the surrounding logic strobes a push with the word to save. On every return it strobes a pop and takes the word shown on the output in that same cycle. The block decides neither when these happen nor what the saved word holds.

A push is never refused. The store is a ring of `DEPTH` slots (default 16, a power of two) of `WIDTH` bits (default 49) under a wrapping top pointer. Once the ring is full, each further push overwrites the oldest slot, so the most recent `DEPTH` words are always kept.

A pop from an empty stack still moves the pointer and returns whatever the wrapped slot holds. A one-cycle debug pulse marks that case. The occupancy count saturates at both ends, and `full_o` and `empty_o` are derived from it. Reset is asynchronous and active low. Its release is expected to be synchronous to `clk`.

Top module: `rstk_circ`

## Requirements
- R1: While reset is active and after its release, `level_o` is 0, `empty_o` is 1, `full_o` is 0 and `underflow_o` is 0.
- R2: Words come out last-in-first-out. A word pushed alone appears on `pop_data_o` in the following cycle.
- R3: Each lone push raises `level_o` by one, up to `DEPTH`, and there it saturates. `full_o` is 1 exactly when `level_o` equals `DEPTH`, and `level_o` never exceeds `DEPTH`.
- R4: After `DEPTH`+k lone pushes, `DEPTH` pops return the last `DEPTH` words pushed, newest first. The k oldest words are lost.
- R5: `pop_data_o` always shows the current top entry, so the popped word can be taken in the same cycle as `pop_i`.
- R6: A lone pop when `level_o` is 0 behaves as follows:
  - `level_o` stays 0.
  - `pop_data_o` shows the slot just below the pointer in that cycle.
  - The pointer still steps down by one slot.
  - `underflow_o` is 1 for exactly the following cycle.
- R7: `push_i` and `pop_i` together show the old top on `pop_data_o` in that cycle and replace the top with `push_data_i`. `level_o` is unchanged.
- R8: A cycle with neither strobe changes neither `level_o` nor `pop_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Save `push_data_i` on top this cycle |
| pop_i | input | 1 | Remove the top entry this cycle |
| push_data_i | input | WIDTH | Word to save |
| pop_data_o | output | WIDTH | Current top entry (combinational) |
| level_o | output | $clog2(DEPTH+1) | Number of valid entries |
| full_o | output | 1 | `level_o` equals `DEPTH` |
| empty_o | output | 1 | `level_o` is 0 |
| underflow_o | output | 1 | Debug pulse, one cycle after a pop on empty |

## Verification
The hardest state to reach from the ports is an underflow pop that returns a known stale word. After reset, the slot below the pointer has never been written. The bench therefore first pushes more words than the depth, so the ring wraps and the oldest entries are overwritten. It then pops the whole stack and pops twice more. The expected stale words follow from the wrapped pointer: the newest word pushed, then the one before it. This also shows that the pointer keeps moving below empty.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_SWAP = 2'b11
  } rstk_op_e;

  function automatic rstk_op_e rstk_decode(input logic push, input logic pop);
    return rstk_op_e'({push, pop});
  endfunction
endpackage

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
  import rstk_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_idx_o,
  output logic [PTR_W-1:0] rd_idx_o,
  output logic [CNT_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             underflow_o
);
  localparam logic [CNT_W-1:0] LVL_MAX = CNT_W'(DEPTH);

  logic [PTR_W-1:0] top_q, top_d;
  logic [CNT_W-1:0] lvl_q, lvl_d;
  logic             unf_q, unf_d;
  logic             state_en;
  rstk_op_e         op;

  assign op       = rstk_decode(push_i, pop_i);
  assign full_o   = (lvl_q == LVL_MAX);
  assign empty_o  = (lvl_q == '0);
  assign state_en = (op != OP_IDLE) || unf_q;

  always_comb begin
    top_d = top_q;
    lvl_d = lvl_q;
    unf_d = 1'b0;
    case (op)
      OP_PUSH: begin
        top_d = top_q + PTR_W'(1);
        if (!full_o) lvl_d = lvl_q + CNT_W'(1);
      end
      OP_POP: begin
        top_d = top_q - PTR_W'(1);
        if (empty_o) unf_d = 1'b1;
        else         lvl_d = lvl_q - CNT_W'(1);
      end
      OP_SWAP: unf_d = empty_o;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      lvl_q <= '0;
      unf_q <= 1'b0;
    end else if (state_en) begin
      top_q <= top_d;
      lvl_q <= lvl_d;
      unf_q <= unf_d;
    end
  end

  assign wr_en_o     = push_i;
  assign wr_idx_o    = (op == OP_SWAP) ? (top_q - PTR_W'(1)) : top_q;
  assign rd_idx_o    = top_q - PTR_W'(1);
  assign level_o     = lvl_q;
  assign underflow_o = unf_q;

  // R3: occupancy bounded by the depth
  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= LVL_MAX);

  // R3: a lone push below full adds one entry
  assert_push_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_o) |=> (level_o == $past(level_o) + CNT_W'(1)));

  // R4: a lone push when full keeps the stack full
  assert_overwrite_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full_o) |=> full_o);

  // R6: a pop on empty keeps the level at zero and pulses the flag
  assert_underflow_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && empty_o) |=> (underflow_o && empty_o));

  // R7: a combined push and pop leaves the occupancy alone
  assert_swap_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> $stable(level_o));

  // R8: an idle cycle changes no occupancy
  assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i) |=> $stable(level_o));
endmodule

// File: rtl/rstk_store.sv
module rstk_store #(
  parameter int WIDTH = 49,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_idx_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [PTR_W-1:0] rd_idx_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en_i && (wr_idx_i == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];
endmodule

// File: rtl/rstk_circ.sv
module rstk_circ #(
  parameter int WIDTH = 49,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] push_data_i,
  output logic [WIDTH-1:0] pop_data_o,
  output logic [CNT_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             underflow_o
);
  logic             wr_en;
  logic [PTR_W-1:0] wr_idx;
  logic [PTR_W-1:0] rd_idx;

  initial begin
    assert_depth_pow2: assert ((DEPTH >= 2) && ((1 << PTR_W) == DEPTH))
      else $error("DEPTH must be a power of two");
  end

  rstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .rd_idx_o    (rd_idx),
    .level_o     (level_o),
    .full_o      (full_o),
    .empty_o     (empty_o),
    .underflow_o (underflow_o)
  );

  rstk_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (push_data_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (pop_data_o)
  );

  // R2: a lone push becomes the visible top next cycle
  assert_push_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |=> (pop_data_o == $past(push_data_i)));

  // R7: a combined push and pop replaces the top
  assert_swap_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> (pop_data_o == $past(push_data_i)));

  // R8: an idle cycle leaves the visible top alone
  assert_idle_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i) |=> $stable(pop_data_o));
endmodule

// File: tb/rstk_circ_test.sv
module rstk_circ_test;
  localparam int WIDTH = 49;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             push_i, pop_i;
  logic [WIDTH-1:0] push_data_i;
  logic [WIDTH-1:0] pop_data_o;
  logic [CNT_W-1:0] level_o;
  logic             full_o, empty_o, underflow_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  rstk_circ #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .push_data_i(push_data_i), .pop_data_o(pop_data_o), .level_o(level_o),
    .full_o(full_o), .empty_o(empty_o), .underflow_o(underflow_o)
  );

  function automatic logic [WIDTH-1:0] val(input int i);
    return 49'h1_2345_6789_0000 + WIDTH'(i) * 49'h0_0101_0011_0101;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle's inputs at the falling edge, settle, return before rising edge
  task automatic step(input logic ps, input logic pp, input logic [WIDTH-1:0] d);
    @(negedge clk);
    push_i = ps; pop_i = pp; push_data_i = d;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; push_i = 0; pop_i = 0; push_data_i = '0;
    #1;
    chk("R1 level in reset", 64'(level_o), 0);
    chk("R1 empty in reset", 64'(empty_o), 1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    step(0, 0, '0);
    chk("R1 level", 64'(level_o), 0);
    chk("R1 empty", 64'(empty_o), 1);
    chk("R1 full", 64'(full_o), 0);
    chk("R1 underflow", 64'(underflow_o), 0);
  endtask

  task automatic t_lifo();
    do_reset();
    for (int i = 0; i < 3; i++) step(1, 0, val(100 + i));
    step(0, 0, '0);
    chk("R5 top visible without pop", 64'(pop_data_o), 64'(val(102)));
    chk("R3 level after three", 64'(level_o), 3);
    step(0, 0, '0);
    chk("R8 idle keeps top", 64'(pop_data_o), 64'(val(102)));
    chk("R8 idle keeps level", 64'(level_o), 3);
    for (int i = 2; i >= 0; i--) begin
      step(0, 1, '0);
      chk("R2 lifo order in pop cycle", 64'(pop_data_o), 64'(val(100 + i)));
    end
    step(0, 0, '0);
    chk("R2 level after draining", 64'(level_o), 0);
    chk("R2 empty after draining", 64'(empty_o), 1);
    chk("R6 no underflow on normal pops", 64'(underflow_o), 0);
  endtask

  task automatic t_overflow_underflow();
    do_reset();
    for (int i = 0; i < DEPTH + 4; i++) begin
      step(1, 0, val(i));
      if (i == DEPTH - 1) begin
        step(0, 0, '0);
        chk("R3 level reaches depth", 64'(level_o), DEPTH);
        chk("R3 full at depth", 64'(full_o), 1);
      end
    end
    step(0, 0, '0);
    chk("R3 level saturates", 64'(level_o), DEPTH);
    chk("R3 full stays", 64'(full_o), 1);
    for (int j = 0; j < DEPTH; j++) begin
      step(0, 1, '0);
      chk("R4 newest kept, oldest lost", 64'(pop_data_o), 64'(val(DEPTH + 3 - j)));
    end
    step(0, 0, '0);
    chk("R4 empty after depth pops", 64'(empty_o), 1);
    step(0, 1, '0);
    chk("R6 stale word on empty pop", 64'(pop_data_o), 64'(val(DEPTH + 3)));
    step(0, 0, '0);
    chk("R6 underflow pulse", 64'(underflow_o), 1);
    chk("R6 level stays zero", 64'(level_o), 0);
    step(0, 0, '0);
    chk("R6 underflow one cycle only", 64'(underflow_o), 0);
    step(0, 1, '0);
    chk("R6 pointer kept moving", 64'(pop_data_o), 64'(val(DEPTH + 2)));
    step(0, 0, '0);
  endtask

  task automatic t_swap();
    do_reset();
    step(1, 0, val(200));
    step(1, 0, val(201));
    step(1, 1, val(202));
    chk("R7 old top shown in swap cycle", 64'(pop_data_o), 64'(val(201)));
    step(0, 0, '0);
    chk("R7 level unchanged", 64'(level_o), 2);
    chk("R7 top replaced", 64'(pop_data_o), 64'(val(202)));
    step(0, 1, '0);
    chk("R7 replaced word pops first", 64'(pop_data_o), 64'(val(202)));
    step(0, 1, '0);
    chk("R7 entry below untouched", 64'(pop_data_o), 64'(val(200)));
    step(0, 0, '0);
    chk("R7 empty afterwards", 64'(empty_o), 1);
  endtask

  initial begin
    rst_n = 1'b0; push_i = 0; pop_i = 0; push_data_i = '0;
    t_reset();
    t_lifo();
    t_overflow_underflow();
    t_swap();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule